// File: doc/BRIEF.md
# Training Mailbox Message Collector

This block is a small bus master that empties the mailbox of a memory-PHY training processor. It reaches the mailbox through a 32-bit register port with a request/acknowledge handshake. For each message it polls a status register until a message is waiting, reads the message, and then runs a two-phase release handshake with the processor. Each complete message word is handed to the rest of the chip as a one-cycle strobe with the word and a flag that marks it as a major word or a stream word.

A major word can be an ordinary progress code, which is reported and then passed over. It can announce a streaming message, which the collector then gathers: a header word and as many argument words as the header names. It can also be a terminal code. On a terminal code the collector stops and reports pass or fail. It then stays in that state until software pulses `start` again.

Register offsets are parameters. The block issues one access at a time and captures read data in the cycle the acknowledge arrives.

Top module: `mbx_collector`

## Requirements
- R1: After reset, `bus_req`, `msg_valid`, `done`, `pass` and `fail` are all 0. No access is issued until `start` is pulsed.
- R2: The collector reads the status register at `STAT_OFS` and keeps reading it while bit 0 is 1. It reads no mailbox register until a status read returns bit 0 = 0.
- R3: Once `bus_req` is raised, it stays high with `bus_we`, `bus_addr` and `bus_wdata` unchanged until the cycle `bus_ack` is high. Read data is taken from `bus_rdata` in that cycle. Only one access is ever outstanding.
- R4: A major message is exactly one read of `MAIL_OFS`. Its full 32-bit value is presented with `msg_valid` = 1 and `msg_is_stream` = 0 before any acknowledge write. `msg_valid` lasts one cycle.
- R5: The release handshake runs after every message word, in this order: write 0 to `ACK_OFS`, read the status register until bit 0 = 1, then write 1 to `ACK_OFS`.
- R6: A stream word is two reads, `MAIL_OFS` then `MAILHI_OFS`, both before the release. The presented word is {bits 15:0 of the second read, bits 15:0 of the first read}, with `msg_is_stream` = 1. The upper 16 bits of both reads are discarded.
- R7: A major word equal to 32'h0000_0008 makes the next word a stream header. Bits 15:0 of the header give N, the number of argument stream words that follow. When N = 0 the next word is a major word again.
- R8: A major word equal to 32'h0000_0007 sets `done` and `pass`. A major word equal to 32'h0000_00FF sets `done` and `fail`. `pass` and `fail` are never both 1. All three hold, with no bus activity, until a `start` pulse clears them in the next cycle and re-arms polling.
- R9: Any other major word is presented and otherwise ignored. The whole 32-bit value is compared, so 32'h0000_0108 is not a stream start. The collector then waits for the next major word.
- R10: A `start` pulse while a message sequence is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that arms the collector from idle or done |
| bus_req | output | 1 | Access request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 16 | Register offset of the access |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | One-cycle completion of the current access |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| msg_valid | output | 1 | One-cycle strobe for a completed message word |
| msg_word | output | 32 | Message word |
| msg_is_stream | output | 1 | 1 = stream (header or argument) word, 0 = major word |
| done | output | 1 | A terminal code was received |
| pass | output | 1 | Terminal code was pass |
| fail | output | 1 | Terminal code was fail |

## Verification
Some properties are checked by assertions on every cycle: the request holds with a stable command until acknowledge, `pass` and `fail` stay exclusive, `done` always carries exactly one result and keeps the bus quiet, and each word strobe lasts one cycle. Other behaviour can only be shown by the bench's mailbox model, which flags any access out of protocol order. That covers the ordering of the ready wait, the data reads and both halves of the release, the half-word assembly, and the header-driven argument count, including N = 0. The terminal decisions, the full-width compare of ignored codes, the re-arm path and a mid-run `start` are also checked there. These scenarios sweep the argument count and both terminal codes.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int unsigned MBX_AW = 16;
    localparam int unsigned MBX_DW = 32;
    localparam int unsigned HALF_W = MBX_DW / 2;

    localparam logic [MBX_DW-1:0] CODE_STREAM = 32'h0000_0008;
    localparam logic [MBX_DW-1:0] CODE_PASS   = 32'h0000_0007;
    localparam logic [MBX_DW-1:0] CODE_FAIL   = 32'h0000_00FF;

    typedef enum logic [2:0] {
        S_IDLE, S_POLL_RDY, S_RD_MAIL, S_RD_HI,
        S_ACK_LO, S_POLL_REL, S_ACK_HI, S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {PH_MAJOR, PH_HDR, PH_ARG} phase_e;

    typedef struct packed {
        logic              we;
        logic [MBX_AW-1:0] addr;
        logic [MBX_DW-1:0] wdata;
    } bus_cmd_t;

    function automatic logic uses_bus(input seq_state_e s);
        return (s != S_IDLE) && (s != S_DONE);
    endfunction

    function automatic bus_cmd_t rd_cmd(input logic [MBX_AW-1:0] a);
        bus_cmd_t c;
        c.we = 1'b0; c.addr = a; c.wdata = '0;
        return c;
    endfunction

    function automatic bus_cmd_t wr_cmd(input logic [MBX_AW-1:0] a, input logic [MBX_DW-1:0] d);
        bus_cmd_t c;
        c.we = 1'b1; c.addr = a; c.wdata = d;
        return c;
    endfunction
endpackage

// File: rtl/mbx_bus_port.sv
module mbx_bus_port
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  bus_cmd_t          cmd,
    input  logic              bus_ack,
    input  logic [MBX_DW-1:0] bus_rdata,
    output logic              bus_req,
    output bus_cmd_t          cmd_q,
    output logic              xfer_done,
    output logic [MBX_DW-1:0] rdata_q
);
    logic busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            cmd_q     <= '0;
            xfer_done <= 1'b0;
            rdata_q   <= '0;
        end else begin
            xfer_done <= 1'b0;
            if (!busy && go) begin
                busy  <= 1'b1;
                cmd_q <= cmd;
            end else if (busy && bus_ack) begin
                busy      <= 1'b0;
                xfer_done <= 1'b1;
                rdata_q   <= bus_rdata;
            end
        end
    end

    assign bus_req = busy;

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !bus_ack) |=> (busy && $stable(cmd_q)));

    // R3
    single_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_ack) |=> (!busy && xfer_done));
endmodule

// File: rtl/mbx_word_asm.sv
module mbx_word_asm
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              major_load,
    input  logic              lo_load,
    input  logic              hi_load,
    input  logic [MBX_DW-1:0] rdata,
    output logic              msg_valid,
    output logic [MBX_DW-1:0] msg_word,
    output logic              msg_is_stream
);
    logic [HALF_W-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q          <= '0;
            msg_valid     <= 1'b0;
            msg_word      <= '0;
            msg_is_stream <= 1'b0;
        end else begin
            msg_valid <= 1'b0;
            if (lo_load)
                lo_q <= rdata[HALF_W-1:0];
            if (major_load) begin
                msg_valid     <= 1'b1;
                msg_word      <= rdata;
                msg_is_stream <= 1'b0;
            end else if (hi_load) begin
                msg_valid     <= 1'b1;
                msg_word      <= {rdata[HALF_W-1:0], lo_q};
                msg_is_stream <= 1'b1;
            end
        end
    end

    // R4
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |=> !msg_valid);
endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
    import mbx_pkg::*;
#(
    parameter logic [MBX_AW-1:0] STAT_OFS   = 16'h0010,
    parameter logic [MBX_AW-1:0] ACK_OFS    = 16'h00C4,
    parameter logic [MBX_AW-1:0] MAIL_OFS   = 16'h00C8,
    parameter logic [MBX_AW-1:0] MAILHI_OFS = 16'h00D0
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              xfer_done,
    input  logic              stat_bit,
    input  logic [MBX_DW-1:0] msg_word,
    output logic              go,
    output bus_cmd_t          cmd,
    output logic              major_load,
    output logic              lo_load,
    output logic              hi_load,
    output logic              done,
    output logic              pass,
    output logic              fail
);
    seq_state_e        state;
    phase_e            phase;
    logic [HALF_W-1:0] args_left;
    logic              issued;

    always_comb begin
        cmd        = '0;
        major_load = 1'b0;
        lo_load    = 1'b0;
        hi_load    = 1'b0;
        unique case (state)
            S_POLL_RDY, S_POLL_REL: cmd = rd_cmd(STAT_OFS);
            S_RD_MAIL:              cmd = rd_cmd(MAIL_OFS);
            S_RD_HI:                cmd = rd_cmd(MAILHI_OFS);
            S_ACK_LO:               cmd = wr_cmd(ACK_OFS, '0);
            S_ACK_HI:               cmd = wr_cmd(ACK_OFS, 32'd1);
            default:                cmd = '0;
        endcase
        go = uses_bus(state) && !issued;
        if (xfer_done && state == S_RD_MAIL) begin
            if (phase == PH_MAJOR) major_load = 1'b1;
            else                   lo_load    = 1'b1;
        end
        if (xfer_done && state == S_RD_HI)
            hi_load = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            phase     <= PH_MAJOR;
            args_left <= '0;
            issued    <= 1'b0;
            pass      <= 1'b0;
            fail      <= 1'b0;
        end else begin
            if (go)             issued <= 1'b1;
            else if (xfer_done) issued <= 1'b0;
            unique case (state)
                S_IDLE, S_DONE: if (start) begin
                    state     <= S_POLL_RDY;
                    phase     <= PH_MAJOR;
                    args_left <= '0;
                    pass      <= 1'b0;
                    fail      <= 1'b0;
                end
                S_POLL_RDY: if (xfer_done && !stat_bit) state <= S_RD_MAIL;
                S_RD_MAIL:  if (xfer_done)
                    state <= (phase == PH_MAJOR) ? S_ACK_LO : S_RD_HI;
                S_RD_HI:    if (xfer_done) state <= S_ACK_LO;
                S_ACK_LO:   if (xfer_done) state <= S_POLL_REL;
                S_POLL_REL: if (xfer_done && stat_bit) state <= S_ACK_HI;
                S_ACK_HI:   if (xfer_done) begin
                    state <= S_POLL_RDY;
                    unique case (phase)
                        PH_MAJOR: begin
                            if (msg_word == CODE_STREAM) phase <= PH_HDR;
                            else if (msg_word == CODE_PASS) begin
                                state <= S_DONE; pass <= 1'b1;
                            end else if (msg_word == CODE_FAIL) begin
                                state <= S_DONE; fail <= 1'b1;
                            end
                        end
                        PH_HDR: begin
                            args_left <= msg_word[HALF_W-1:0];
                            phase     <= (msg_word[HALF_W-1:0] == '0) ? PH_MAJOR : PH_ARG;
                        end
                        default: begin
                            if (args_left == HALF_W'(1)) phase <= PH_MAJOR;
                            args_left <= args_left - HALF_W'(1);
                        end
                    endcase
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign done = (state == S_DONE);

    // R8
    pass_fail_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pass && fail));

    // R8
    done_result_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (pass ^ fail));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(pass) && $stable(fail)));
endmodule

// File: rtl/mbx_collector.sv
module mbx_collector
    import mbx_pkg::*;
#(
    parameter logic [MBX_AW-1:0] STAT_OFS   = 16'h0010,
    parameter logic [MBX_AW-1:0] ACK_OFS    = 16'h00C4,
    parameter logic [MBX_AW-1:0] MAIL_OFS   = 16'h00C8,
    parameter logic [MBX_AW-1:0] MAILHI_OFS = 16'h00D0
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              bus_req,
    output logic              bus_we,
    output logic [MBX_AW-1:0] bus_addr,
    output logic [MBX_DW-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [MBX_DW-1:0] bus_rdata,
    output logic              msg_valid,
    output logic [MBX_DW-1:0] msg_word,
    output logic              msg_is_stream,
    output logic              done,
    output logic              pass,
    output logic              fail
);
    bus_cmd_t          cmd, cmd_q;
    logic              go, xfer_done;
    logic [MBX_DW-1:0] rdata_q;
    logic              major_load, lo_load, hi_load;

    mbx_seq #(
        .STAT_OFS(STAT_OFS), .ACK_OFS(ACK_OFS),
        .MAIL_OFS(MAIL_OFS), .MAILHI_OFS(MAILHI_OFS)
    ) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .xfer_done(xfer_done), .stat_bit(rdata_q[0]), .msg_word(msg_word),
        .go(go), .cmd(cmd),
        .major_load(major_load), .lo_load(lo_load), .hi_load(hi_load),
        .done(done), .pass(pass), .fail(fail)
    );

    mbx_bus_port u_port (
        .clk(clk), .rst(rst), .go(go), .cmd(cmd),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .bus_req(bus_req), .cmd_q(cmd_q),
        .xfer_done(xfer_done), .rdata_q(rdata_q)
    );

    mbx_word_asm u_asm (
        .clk(clk), .rst(rst),
        .major_load(major_load), .lo_load(lo_load), .hi_load(hi_load),
        .rdata(rdata_q),
        .msg_valid(msg_valid), .msg_word(msg_word), .msg_is_stream(msg_is_stream)
    );

    assign bus_we    = cmd_q.we;
    assign bus_addr  = cmd_q.addr;
    assign bus_wdata = cmd_q.wdata;

    // R8
    done_quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !bus_req);
endmodule

// File: tb/sim_mbx_collector.sv
`timescale 1ns/1ps
module sim_mbx_collector;
    localparam logic [15:0] A_STAT = 16'h0010;
    localparam logic [15:0] A_ACK  = 16'h00C4;
    localparam logic [15:0] A_MAIL = 16'h00C8;
    localparam logic [15:0] A_HI   = 16'h00D0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        bus_req, bus_we, bus_ack;
    logic [15:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        msg_valid, msg_is_stream, done, pass, fail;
    logic [31:0] msg_word;

    always #4 clk = ~clk;

    mbx_collector #(.STAT_OFS(A_STAT), .ACK_OFS(A_ACK), .MAIL_OFS(A_MAIL), .MAILHI_OFS(A_HI)) u0 (
        .clk(clk), .rst(rst), .start(start),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .msg_valid(msg_valid), .msg_word(msg_word), .msg_is_stream(msg_is_stream),
        .done(done), .pass(pass), .fail(fail)
    );

    int tests = 0;
    int fails = 0;

    // mailbox model
    logic [31:0] mail_val [16];
    logic [31:0] hi_val   [16];
    logic        strm     [16];
    logic [31:0] exp_word [16];
    int m_len, m_idx, m_st, m_hold, m_reads, viol, stat_reads;
    int lat_cnt = 0, lat_sel = 0;
    logic [31:0] got_word [32];
    logic        got_strm [32];
    int got_n = 0;

    task automatic serve(output logic [31:0] r);
        r = 32'hFFFF_FFFF;
        if (!bus_we && bus_addr == A_STAT) begin
            stat_reads++;
            case (m_st)
                0: if (m_hold > 0) begin m_hold--; r = 32'h1; end
                   else if (m_idx < m_len) begin m_st = 1; r = 32'hFFFF_FFFE; end
                   else r = 32'h1;
                1: r = 32'hFFFF_FFFE;
                2: if (m_hold > 0) begin m_hold--; r = 32'h0; end
                   else begin m_st = 3; r = 32'h1; end
                default: r = 32'h1;
            endcase
        end else if (!bus_we && bus_addr == A_MAIL) begin
            if (m_st != 1 || m_reads != 0) viol++;
            m_reads++;
            r = mail_val[m_idx];
        end else if (!bus_we && bus_addr == A_HI) begin
            if (m_st != 1 || !strm[m_idx] || m_reads != 1) viol++;
            m_reads++;
            r = hi_val[m_idx];
        end else if (bus_we && bus_addr == A_ACK && bus_wdata == 32'h0) begin
            if (m_st != 1 || m_reads != (strm[m_idx] ? 2 : 1)) viol++;
            m_st = 2; m_hold = 2;
        end else if (bus_we && bus_addr == A_ACK && bus_wdata == 32'h1) begin
            if (m_st != 3) viol++;
            m_st = 0; m_idx++; m_hold = 3; m_reads = 0;
        end else viol++;
    endtask

    always @(posedge clk) begin
        logic [31:0] r;
        if (rst) bus_ack <= 1'b0;
        else if (bus_ack) bus_ack <= 1'b0;
        else if (bus_req) begin
            if (lat_cnt >= lat_sel) begin
                lat_cnt = 0;
                lat_sel = (lat_sel + 1) % 3;
                serve(r);
                bus_rdata <= r;
                bus_ack <= 1'b1;
            end else lat_cnt++;
        end
    end

    always @(negedge clk) begin
        if (!rst && msg_valid && got_n < 32) begin
            got_word[got_n] = msg_word;
            got_strm[got_n] = msg_is_stream;
            got_n++;
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic add_major(inout int k, input logic [31:0] v);
        mail_val[k] = v; hi_val[k] = 32'hBAD0_0000; strm[k] = 1'b0; exp_word[k] = v; k++;
    endtask

    task automatic add_stream(inout int k, input logic [31:0] w);
        mail_val[k] = {16'hA5A5, w[15:0]}; hi_val[k] = {16'h5A5A, w[31:16]};
        strm[k] = 1'b1; exp_word[k] = w; k++;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic run_case(input int n, input logic [31:0] term, input bit poke);
        int k = 0;
        add_major(k, 32'h0000_0108 + (n << 12));          // R9 noise code
        add_major(k, 32'h0000_0008);                      // R7 stream start
        add_stream(k, {16'(16'h00C0 + n), 16'(n)});       // R7 header
        for (int a = 0; a < n; a++)
            add_stream(k, 32'h1000_0001 * (a + 1) + (n << 8));
        add_major(k, term);
        m_len = k; m_idx = 0; m_st = 0; m_hold = 3; m_reads = 0;
        viol = 0; stat_reads = 0; got_n = 0;
        pulse_start();
        if (poke) begin
            for (int c = 0; c < 3000 && got_n < 3; c++) @(negedge clk);
            pulse_start();                                // R10 mid-run start
        end
        for (int c = 0; c < 8000 && !done; c++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(got_n == m_len, "R7", "word count", got_n, m_len);
        for (int i = 0; i < m_len && i < got_n; i++) begin
            chk(got_word[i] == exp_word[i], strm[i] ? "R6" : "R4", "word", got_word[i], exp_word[i]);
            chk(got_strm[i] == strm[i], "R6", "stream flag", 32'(got_strm[i]), 32'(strm[i]));
        end
        chk(done == 1'b1, "R8", "done", 32'(done), 1);
        chk(pass == (term == 32'h7), "R8", "pass", 32'(pass), 32'(term == 32'h7));
        chk(fail == (term == 32'hFF), "R8", "fail", 32'(fail), 32'(term == 32'hFF));
        chk(viol == 0, "R5", "protocol violations", viol, 0);
        chk(stat_reads >= 7 * m_len, "R2", "status polls", stat_reads, 7 * m_len);
        if (poke) chk(m_idx == m_len, "R10", "entries consumed", m_idx, m_len);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        bit idle_ok = 1'b1;
        m_len = 0; m_idx = 0; m_st = 0; m_hold = 0; m_reads = 0; viol = 0; stat_reads = 0;
        bus_rdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (bus_req || msg_valid || done || pass || fail) idle_ok = 1'b0;
        end
        chk(idle_ok, "R1", "outputs quiet after reset", 32'(idle_ok), 1);

        for (int n = 0; n < 4; n++) begin
            run_case(n, 32'h0000_0007, n == 2);
            run_case(n, 32'h0000_00FF, 1'b0);
        end

        // R8 result persists without start
        repeat (20) @(negedge clk);
        chk(done && fail && !pass && !bus_req, "R8", "held done/fail", {done, fail, pass, bus_req}, 4'b1100);

        // R8 start re-arms; R2 empty mailbox keeps polling without reads
        m_len = 0; m_idx = 0; m_st = 0; m_hold = 0; m_reads = 0; viol = 0; stat_reads = 0; got_n = 0;
        pulse_start();
        chk(!done && !pass && !fail, "R8", "cleared by start", {done, pass, fail}, 0);
        repeat (60) @(negedge clk);
        chk(stat_reads > 3, "R2", "polling continues", stat_reads, 4);
        chk(viol == 0 && got_n == 0, "R2", "no read while not ready", viol + got_n, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule